// File: doc/BRIEF.md
# Instruction-Stepped Add and Multiply Pipelines

This block is an integer arithmetic unit with two independent pipelines: an adder two stages deep and a multiplier three stages deep. A pipeline moves only when an instruction for that unit is issued. Any cycle without an instruction leaves the pipeline untouched. Operands come from a small register file. Each unit has two source indices, so both units can read their operands in the same cycle. Registers are loaded through a single write port.

Each issued instruction is either real or a dummy. A real instruction computes a result from its two source registers. A dummy carries no operands. In both cases the instruction shifts its pipeline by one place, and the entry that reaches the last stage appears on the unit's registered output, together with that entry's valid flag.

To drain a result, software issues further instructions of the same kind, either dummies or the next real operations. If the adder and multiplier are both issued every cycle, the block delivers two results per cycle.

Top module: `dual_step_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, every stage valid flag is cleared, so `add_res_valid` and `mul_res_valid` read 0 after that edge. The same edge sets every register of the file to 0.
- R2: A real add issued at edge k appears on `add_res` with `add_res_valid`=1 after the next edge at which an add (real or dummy) is issued, and not before.
- R3: A real multiply appears on `mul_res` with `mul_res_valid`=1 after the second later edge at which a multiply is issued. After only one further multiply, `mul_res_valid` is still 0 for it.
- R4: At an edge with no instruction for a unit, that unit's stage contents, `*_res` and `*_res_valid` keep their values.
- R5: A dummy instruction (`*_issue`=1, `*_real`=0) still shifts the pipeline. It inserts an invalid entry, which shows `*_res_valid`=0 when it reaches the output.
- R6: When a unit is issued real instructions on consecutive edges, a new valid result appears after every edge once the pipeline is full, in issue order.
- R7: The add result is the 32-bit sum wrapped modulo 2^32. For example, 0x7FFFFFFF + 1 gives 0x80000000.
- R8: The multiply result is the low 32 bits of the two's-complement product of the signed operands. For example, -4 × 0x7FFFFFFF gives 0x00000004, and -3 × 5 gives 0xFFFFFFF1.
- R9: The adder and multiplier may be issued at the same edge. Each advances and produces results independently of the other.
- R10: With `wr_en`=1, `wr_data` is written into register `wr_idx` (3 bits, registers 0 to 7) at the edge. An instruction issued at that same edge reads the old value, and instructions at later edges read the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register file write enable |
| wr_idx | input | 3 | Register to write |
| wr_data | input | 32 | Data written |
| add_issue | input | 1 | Add instruction issued this cycle |
| add_real | input | 1 | 1: real add, 0: dummy |
| add_src_a | input | 3 | First add source register |
| add_src_b | input | 3 | Second add source register |
| mul_issue | input | 1 | Multiply instruction issued this cycle |
| mul_real | input | 1 | 1: real multiply, 0: dummy |
| mul_src_a | input | 3 | First multiply source register |
| mul_src_b | input | 3 | Second multiply source register |
| add_res | output | 32 | Adder output entry |
| add_res_valid | output | 1 | Adder output entry is a real result |
| mul_res | output | 32 | Multiplier output entry |
| mul_res_valid | output | 1 | Multiplier output entry is a real result |

## Verification
Result timing is counted in issued instructions, not in clock cycles. An add sum is due right after the next add edge. A product is due after the second multiply edge that follows it, however many idle cycles fall in between. The bench drives each instruction for exactly one edge and samples on the falling edge that follows. It checks the output both before and at the edge where each result is due. It also inserts idle cycles between pushes to show that the due edge depends on instruction count only.

// File: rtl/pipe_pkg.sv
// Shared definitions for the instruction-stepped arithmetic unit.
package pipe_pkg;
    // Selects which operation a stepped pipeline computes.
    typedef enum logic [0:0] {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } op_e;
endpackage

// File: rtl/operand_file.sv
// Operand register file: one synchronous write port and four
// asynchronous read ports (two per arithmetic unit).
// Assumes a read in the same cycle as a write to that register
// returns the value held before the write edge.
module operand_file #(
    parameter int W     = 32,
    parameter int NREG  = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [W-1:0]    wr_data,
    input  logic [IDXW-1:0] rd_idx0,
    input  logic [IDXW-1:0] rd_idx1,
    input  logic [IDXW-1:0] rd_idx2,
    input  logic [IDXW-1:0] rd_idx3,
    output logic [W-1:0]    rd_dat0,
    output logic [W-1:0]    rd_dat1,
    output logic [W-1:0]    rd_dat2,
    output logic [W-1:0]    rd_dat3
);
    logic [W-1:0] regs [NREG];

    // Clear all registers on reset, otherwise apply the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // Read ports see the registered contents.
    assign rd_dat0 = regs[rd_idx0];
    assign rd_dat1 = regs[rd_idx1];
    assign rd_dat2 = regs[rd_idx2];
    assign rd_dat3 = regs[rd_idx3];

    // R10: a written value is present in the next cycle.
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/step_pipe.sv
// Instruction-stepped pipeline of DEPTH stages. The last stage is the
// output register. A new entry enters stage 0 only when an instruction
// is issued; the same issue shifts every stage by one place. A dummy
// inserts an invalid bubble. With no issue, all stages hold.
// Assumes DEPTH >= 2.
module step_pipe
    import pipe_pkg::*;
#(
    parameter int  W     = 32,
    parameter int  DEPTH = 2,
    parameter op_e OP    = OP_ADD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic         real_op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res,
    output logic         res_vld
);
    localparam int LAST = DEPTH - 1;

    logic [W-1:0]     dat [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [W-1:0]     fresh;

    // Compute the new entry for the chosen operation.
    generate
        if (OP == OP_ADD) begin : g_add
            assign fresh = opa + opb;  // wraps modulo 2^W
        end else begin : g_mul
            // A W-bit product equals the low W bits of the signed product.
            assign fresh = opa * opb;
        end
    endgenerate

    // Valid bits: cleared on reset, shifted on each issue.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= '0;
        else if (issue) vld <= {vld[DEPTH-2:0], real_op};
    end

    // Data stages: shift on each issue, otherwise hold.
    always_ff @(posedge clk) begin
        if (issue) begin
            dat[0] <= fresh;
            for (int i = 1; i < DEPTH; i++) dat[i] <= dat[i-1];
        end
    end

    assign res     = dat[LAST];
    assign res_vld = vld[LAST];

    // R1: reset empties every stage.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> vld == '0);
    // R4: no issue, no movement.
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(vld) && $stable(res));
    // R5: a dummy enters as an invalid entry.
    a_r5_dummy_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !real_op |=> !vld[0]);
    // R2/R3: the output flag is the one held one stage earlier.
    a_r2_out_from_prev: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> res_vld == $past(vld[DEPTH-2]));
endmodule

// File: rtl/dual_step_alu.sv
// Top level: operand register file feeding a two-stage adder and a
// three-stage multiplier. Each unit advances only on its own issue.
// Assumes the issuing logic keeps *_real stable with *_issue.
module dual_step_alu
    import pipe_pkg::*;
#(
    parameter int W         = 32,
    parameter int NREG      = 8,
    parameter int ADD_DEPTH = 2,
    parameter int MUL_DEPTH = 3,
    localparam int IDXW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [W-1:0]    wr_data,
    input  logic            add_issue,
    input  logic            add_real,
    input  logic [IDXW-1:0] add_src_a,
    input  logic [IDXW-1:0] add_src_b,
    input  logic            mul_issue,
    input  logic            mul_real,
    input  logic [IDXW-1:0] mul_src_a,
    input  logic [IDXW-1:0] mul_src_b,
    output logic [W-1:0]    add_res,
    output logic            add_res_valid,
    output logic [W-1:0]    mul_res,
    output logic            mul_res_valid
);
    logic [W-1:0] add_a, add_b, mul_a, mul_b;

    operand_file #(.W(W), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx0(add_src_a), .rd_idx1(add_src_b),
        .rd_idx2(mul_src_a), .rd_idx3(mul_src_b),
        .rd_dat0(add_a), .rd_dat1(add_b),
        .rd_dat2(mul_a), .rd_dat3(mul_b)
    );

    step_pipe #(.W(W), .DEPTH(ADD_DEPTH), .OP(OP_ADD)) u_add (
        .clk(clk), .rst_n(rst_n),
        .issue(add_issue), .real_op(add_real),
        .opa(add_a), .opb(add_b),
        .res(add_res), .res_vld(add_res_valid)
    );

    step_pipe #(.W(W), .DEPTH(MUL_DEPTH), .OP(OP_MUL)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .issue(mul_issue), .real_op(mul_real),
        .opa(mul_a), .opb(mul_b),
        .res(mul_res), .res_vld(mul_res_valid)
    );

    // R9: the multiplier output never moves on an add-only edge.
    a_r9_units_apart: assert property (@(posedge clk) disable iff (!rst_n)
        add_issue && !mul_issue |=> $stable(mul_res_valid) && $stable(mul_res));
endmodule

// File: tb/dual_step_alu_test.sv
`timescale 1ns/1ps
module dual_step_alu_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_idx = 0;
    logic [31:0] wr_data = 0;
    logic        add_issue = 0, add_real = 0;
    logic [2:0]  add_src_a = 0, add_src_b = 0;
    logic        mul_issue = 0, mul_real = 0;
    logic [2:0]  mul_src_a = 0, mul_src_b = 0;
    logic [31:0] add_res, mul_res;
    logic        add_res_valid, mul_res_valid;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_step_alu uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .add_issue(add_issue), .add_real(add_real),
        .add_src_a(add_src_a), .add_src_b(add_src_b),
        .mul_issue(mul_issue), .mul_real(mul_real),
        .mul_src_a(mul_src_a), .mul_src_b(mul_src_b),
        .add_res(add_res), .add_res_valid(add_res_valid),
        .mul_res(mul_res), .mul_res_valid(mul_res_valid)
    );

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One edge with the given instructions, then sample at the falling edge.
    task automatic step(input bit ai, input bit ar, input int aa, input int ab,
                        input bit mi, input bit mr, input int ma, input int mb);
        add_issue = ai; add_real = ar; add_src_a = 3'(aa); add_src_b = 3'(ab);
        mul_issue = mi; mul_real = mr; mul_src_a = 3'(ma); mul_src_b = 3'(mb);
        @(negedge clk);
        add_issue = 0; add_real = 0; mul_issue = 0; mul_real = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wreg(input int idx, input logic [31:0] val);
        wr_en = 1; wr_idx = 3'(idx); wr_data = val;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle(2);
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "add valid after reset", 32'(add_res_valid), 0);
        chk("R1", "mul valid after reset", 32'(mul_res_valid), 0);
        step(1, 1, 6, 7, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R1", "registers read zero", add_res, 0);
    endtask

    task automatic load_regs();
        wreg(1, 5); wreg(2, 7); wreg(3, -3);
        wreg(4, 32'h7FFF_FFFF); wreg(5, 1); wreg(6, -4);
    endtask

    task automatic t_add_timing();
        step(1, 1, 1, 2, 0, 0, 0, 0);
        chk("R2", "no result after first add", 32'(add_res_valid), 0);
        step(1, 1, 1, 3, 0, 0, 0, 0);
        chk("R2", "sum valid", 32'(add_res_valid), 1);
        chk("R2", "sum 5+7", add_res, 12);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R2", "second sum 5-3", add_res, 2);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R5", "dummy bubble reaches output", 32'(add_res_valid), 0);
    endtask

    task automatic t_mul_timing();
        step(0, 0, 0, 0, 1, 1, 1, 2);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R3", "product not out after one push", 32'(mul_res_valid), 0);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R3", "product valid after two pushes", 32'(mul_res_valid), 1);
        chk("R3", "product 5*7", mul_res, 35);
    endtask

    task automatic t_hold();
        step(1, 1, 1, 2, 0, 0, 0, 0);
        idle(3);
        chk("R4", "add output held invalid", 32'(add_res_valid), 0);
        chk("R4", "mul output held", mul_res, 35);
        chk("R4", "mul valid held", 32'(mul_res_valid), 1);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R4", "held sum emerges on push", add_res, 12);
        step(0, 0, 0, 0, 1, 1, 3, 1);
        idle(4);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        idle(2);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R8", "-3*5 after idle gaps", mul_res, 32'hFFFF_FFF1);
    endtask

    task automatic t_stream();
        step(1, 1, 1, 1, 1, 1, 1, 1);
        step(1, 1, 2, 2, 1, 1, 2, 2);
        chk("R6", "add stream #1", add_res, 10);
        step(1, 1, 1, 2, 1, 1, 1, 2);
        chk("R6", "add stream #2", add_res, 14);
        chk("R6", "mul stream #1", mul_res, 25);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        chk("R6", "add stream #3", add_res, 12);
        chk("R6", "mul stream #2", mul_res, 49);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R6", "mul stream #3", mul_res, 35);
        chk("R9", "add unchanged by mul push", add_res, 12);
    endtask

    task automatic t_wrap();
        step(1, 1, 4, 5, 1, 1, 6, 4);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        chk("R7", "0x7FFFFFFF+1 wraps", add_res, 32'h8000_0000);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R8", "-4*0x7FFFFFFF low bits", mul_res, 32'h0000_0004);
    endtask

    task automatic t_both();
        step(1, 1, 2, 3, 1, 1, 3, 3);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        chk("R9", "add result with mul stepped", add_res, 4);
        chk("R9", "mul not yet out", 32'(mul_res_valid), 0);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R9", "mul -3*-3", mul_res, 9);
        chk("R9", "add held during mul push", add_res, 4);
    endtask

    task automatic t_write_order();
        wr_en = 1; wr_idx = 3'd7; wr_data = 100;
        step(1, 1, 7, 1, 0, 0, 0, 0);
        wr_en = 0;
        step(1, 1, 7, 1, 0, 0, 0, 0);
        chk("R10", "same-edge read sees old value", add_res, 5);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R10", "later read sees new value", add_res, 105);
    endtask

    task automatic t_reset_midrun();
        step(1, 1, 1, 2, 1, 1, 1, 2);
        step(1, 1, 1, 2, 1, 1, 1, 2);
        do_reset();
        chk("R1", "add valid cleared mid-run", 32'(add_res_valid), 0);
        chk("R1", "mul valid cleared mid-run", 32'(mul_res_valid), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        load_regs();
        t_add_timing();
        t_mul_timing();
        t_hold();
        t_stream();
        t_wrap();
        t_both();
        t_write_order();
        t_reset_midrun();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule